// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block receives asynchronous serial characters on a single line. It oversamples the line once per cycle of an external single-cycle rate enable, counting either 16 or 8 enables per bit. It validates a start bit at the middle of the bit and votes each later bit from samples taken near the bit centre. A character has 5 to 9 data bits, sent least significant bit first, then an optional even or odd parity bit and one stop bit. Each completed character is stored in a two-entry buffer together with its own frame-error and parity-error flags. One further completed character can wait in the receive shift stage while the buffer is full.

Software reaches the block through a small register port. Address 0 reads the oldest character, and that read removes it from the buffer. Address 1 holds status. Address 2 holds control. A receive-ready output and a gated interrupt output follow the buffer state. A multiprocessor filtering mode switches to 9-bit characters and discards every character whose ninth bit is zero, so that only address characters reach the buffer.

Top module: `uart_rx_buffered`

## Requirements
- R1: After reset, reads of addresses 0, 1 and 2 all return 0x00, and `rx_ready` and `rx_irq` are low.
- R2: The line idles high. A character is a low start bit, N data bits sent LSB first, an optional parity bit, and one stop bit. N is 5 plus control bits [6:4] when that field is 0 to 4, and N is 9 for field values 5 to 7. A read of address 0 returns data bits [7:0], zero-extended. Control read bit 7 returns data bit 8 of the head character.
- R3: The buffer holds two characters and returns them oldest first. Status bit 0 and `rx_ready` are high while the buffer holds a character. A read of address 0 removes the head character.
- R4: A character that completes while the buffer is full waits in the shift stage. It enters the buffer in the cycle of the next address-0 read.
- R5: Status bit 3 (overrun) is set when three things happen together: a start bit is validated, the buffer is full, and a character is waiting, with no address-0 read in that same cycle. The waiting character is then discarded. The flag clears on the next address-0 read. If a read falls in that same cycle, no overrun is flagged and the waiting character enters the buffer.
- R6: Status bit 1 is high when the head character's stop bit was sampled low, and low when that stop bit was sampled high.
- R7: Control bits [3:2] select the parity mode: 10 for even, 11 for odd, and 0x for no parity bit. Status bit 2 flags a parity mismatch for the head character. It can be set only if parity was enabled when that character's start was detected. Later control writes do not change a flag that is already stored.
- R8: The status error flags always describe the current head character. After an address-0 read they show the next entry.
- R9: Status bit 4 selects 8 rate enables per bit instead of 16.
- R10: Status bit 5 turns on multiprocessor filtering. In this mode characters have 9 data bits. A character whose ninth bit is 0 is dropped: it is not stored and sets no flag. A character whose ninth bit is 1 is stored.
- R11: `rx_irq` is high exactly when control bit 1, `gie` and the receive-ready state are all high.
- R12: A write to address 1 changes only status bits 4 and 5. The ready and error bits are unaffected by it.
- R13: If the start bit reads high at its middle, the receiver returns to idle and stores nothing.
- R14: When control bit 0 (receiver enable) is low, incoming characters are not received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Single-cycle oversampling enable |
| rxd | input | 1 | Serial receive line, idle high |
| gie | input | 1 | Global interrupt enable |
| reg_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe; at address 0 it removes the head character |
| reg_rdata | output | 8 | Register read data, combinational from address |
| rx_ready | output | 1 | Buffer holds at least one character |
| rx_irq | output | 1 | Receive-complete interrupt |

## Verification
The two functions that can coincide are the data-port read and the start-bit validation that would declare an overrun. Both touch the waiting character in the same cycle. The bench fills the buffer, leaves a third character waiting, and then starts a fourth frame. It asserts the address-0 read in exactly the cycle in which that frame's start bit is judged at mid-bit. It expects no overrun flag and expects all of the second, third and fourth characters to be delivered in order. A companion case without the read expects the overrun flag and the loss of the third character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int MAX_BITS = 9;
  localparam int OSR_NORM = 16;
  localparam int OSR_FAST = 8;
  localparam int CNT_W    = $clog2(OSR_NORM);
  localparam int IDX_W    = $clog2(MAX_BITS + 1);

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                ferr;
    logic                perr;
  } rx_entry_t;

  // Number of data bits for a size code; filtering mode forces 9.
  function automatic logic [IDX_W-1:0] frame_bits(input logic [2:0] code, input logic mp);
    if (mp || code > 3'd4) return IDX_W'(MAX_BITS);
    return IDX_W'(5) + IDX_W'(code);
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Bit decision: majority of three at x16, both samples high at x8.
  function automatic logic bit_vote(input logic fast, input logic sa, input logic sb,
                                    input logic now);
    return fast ? (sa & now) : maj3(sa, sb, now);
  endfunction

  function automatic logic [CNT_W-1:0] osr_last(input logic fast);
    return fast ? CNT_W'(OSR_FAST - 1) : CNT_W'(OSR_NORM - 1);
  endfunction

  function automatic logic [CNT_W-1:0] pos_first(input logic fast);
    return fast ? CNT_W'(OSR_FAST / 2 - 1) : CNT_W'(OSR_NORM / 2 - 1);
  endfunction

  function automatic logic [CNT_W-1:0] pos_second(input logic fast);
    return fast ? CNT_W'(OSR_FAST / 2) : CNT_W'(OSR_NORM / 2);
  endfunction

  function automatic logic [CNT_W-1:0] pos_decide(input logic fast);
    return fast ? CNT_W'(OSR_FAST / 2) : CNT_W'(OSR_NORM / 2 + 1);
  endfunction

  // Expected parity bit over the received data (unused bits are zero).
  function automatic logic parity_of(input logic [MAX_BITS-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rx_in,
  input  logic                enable,
  input  logic                fast_cfg,
  input  logic                mp_cfg,
  input  logic [2:0]          size_code,
  input  logic                par_en,
  input  logic                par_odd,
  output logic                start_ok,
  output logic                frame_done,
  output logic [MAX_BITS-1:0] frame_word,
  output logic                frame_ferr,
  output logic                frame_perr
);
  rx_state_e           state_q;
  logic [CNT_W-1:0]    sc_q;
  logic [IDX_W-1:0]    idx_q, nb_q;
  logic                fast_q, pen_q, podd_q, sa_q, sb_q, perr_q;
  logic [MAX_BITS-1:0] sh_q;
  logic                decide, vote;

  assign decide     = tick && (state_q != RX_IDLE) && (sc_q == pos_decide(fast_q));
  assign vote       = bit_vote(fast_q, sa_q, sb_q, rx_in);
  assign start_ok   = decide && (state_q == RX_START) && !vote;
  assign frame_done = decide && (state_q == RX_STOP);
  assign frame_word = sh_q;
  assign frame_ferr = !vote;
  assign frame_perr = perr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      sc_q    <= '0;
      idx_q   <= '0;
      nb_q    <= '0;
      fast_q  <= 1'b0;
      pen_q   <= 1'b0;
      podd_q  <= 1'b0;
      sa_q    <= 1'b1;
      sb_q    <= 1'b1;
      perr_q  <= 1'b0;
      sh_q    <= '0;
    end else if (!enable) begin
      state_q <= RX_IDLE;
    end else if (tick) begin
      if (state_q == RX_IDLE) begin
        if (!rx_in) begin
          state_q <= RX_START;
          sc_q    <= '0;
          fast_q  <= fast_cfg;
          pen_q   <= par_en;
          podd_q  <= par_odd;
          nb_q    <= frame_bits(size_code, mp_cfg);
        end
      end else begin
        sc_q <= (sc_q == osr_last(fast_q)) ? '0 : sc_q + 1'b1;
        if (sc_q == pos_first(fast_q))  sa_q <= rx_in;
        if (sc_q == pos_second(fast_q)) sb_q <= rx_in;
        if (decide) begin
          unique case (state_q)
            RX_START: begin
              if (vote) begin
                state_q <= RX_IDLE;
              end else begin
                state_q <= RX_DATA;
                idx_q   <= '0;
                sh_q    <= '0;
                perr_q  <= 1'b0;
              end
            end
            RX_DATA: begin
              sh_q[idx_q] <= vote;
              idx_q       <= idx_q + 1'b1;
              if (idx_q == nb_q - 1'b1) state_q <= pen_q ? RX_PARITY : RX_STOP;
            end
            RX_PARITY: begin
              perr_q  <= (vote != parity_of(sh_q, podd_q));
              state_q <= RX_STOP;
            end
            RX_STOP:  state_q <= RX_IDLE;
            default:  state_q <= RX_IDLE;
          endcase
        end
      end
    end
  end

  // R9: at double speed the bit counter never leaves the 8-sample range
  a_r9_fast_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != RX_IDLE) && fast_q) |-> (sc_q < CNT_W'(OSR_FAST)));

  // R2: the data bit index stays inside the configured character size
  a_r2_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_DATA) |-> (idx_q < nb_q));

  // R13: a completed character is always preceded by an accepted start
  a_r13_done_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (state_q == RX_STOP) && $stable(nb_q));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rx_entry_t push_entry,
  input  logic      pop,
  output rx_entry_t head,
  output logic      empty,
  output logic      full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_entry_t        slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign head  = slot_q[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (push && wr_q == PTR_W'(i)) slot_q[i] <= push_entry;
      if (push) wr_q <= nxt(wr_q);
      if (pop)  rd_q <= nxt(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3: never written past two entries
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  // R3: never read when empty
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/uart_rx_buffered.sv
module uart_rx_buffered
  import uart_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BUF_DEPTH   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic       gie,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  output logic       rx_ready,
  output logic       rx_irq
);
  logic [6:0] ctrl_q;
  logic       fast_q, mpm_q, ovr_q;
  logic       pend_valid_q;
  rx_entry_t  pend_q;

  logic                rx_s;
  logic                start_ok, frame_done, frame_ferr, frame_perr;
  logic [MAX_BITS-1:0] frame_word;
  rx_entry_t           new_entry, push_entry, head;
  logic                fifo_push, fifo_empty, fifo_full;
  logic                pop, frame_keep, pend_move, ovr_evt;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  uart_rx_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx_in(rx_s),
    .enable(ctrl_q[0]), .fast_cfg(fast_q), .mp_cfg(mpm_q),
    .size_code(ctrl_q[6:4]), .par_en(ctrl_q[3]), .par_odd(ctrl_q[2]),
    .start_ok(start_ok), .frame_done(frame_done), .frame_word(frame_word),
    .frame_ferr(frame_ferr), .frame_perr(frame_perr)
  );

  uart_rx_fifo #(.DEPTH(BUF_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .push_entry(push_entry),
    .pop(pop), .head(head), .empty(fifo_empty), .full(fifo_full)
  );

  // Named internal events
  assign pop        = reg_rd && (reg_addr == ADDR_DATA) && !fifo_empty;
  assign frame_keep = frame_done && (!mpm_q || frame_word[MAX_BITS-1]);
  assign pend_move  = pend_valid_q && pop;
  assign ovr_evt    = start_ok && pend_valid_q && fifo_full && !pop;
  assign new_entry  = '{data: frame_word, ferr: frame_ferr, perr: frame_perr};
  assign fifo_push  = pend_move || (frame_keep && (!fifo_full || pop));
  assign push_entry = pend_move ? pend_q : new_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid_q <= 1'b0;
      pend_q       <= '0;
      ovr_q        <= 1'b0;
    end else begin
      if (ovr_evt) begin
        pend_valid_q <= 1'b0;
      end else if (pend_move) begin
        pend_valid_q <= frame_keep;
        if (frame_keep) pend_q <= new_entry;
      end else if (frame_keep && fifo_full && !pop) begin
        pend_valid_q <= 1'b1;
        pend_q       <= new_entry;
      end
      if (pop)          ovr_q <= 1'b0;
      else if (ovr_evt) ovr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fast_q <= 1'b0;
      mpm_q  <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_STAT) begin
        fast_q <= reg_wdata[4];
        mpm_q  <= reg_wdata[5];
      end else if (reg_addr == ADDR_CTRL) begin
        ctrl_q <= reg_wdata[6:0];
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_DATA: reg_rdata = fifo_empty ? 8'h00 : head.data[7:0];
      ADDR_STAT: reg_rdata = {2'b00, mpm_q, fast_q, ovr_q,
                              head.perr & !fifo_empty, head.ferr & !fifo_empty, !fifo_empty};
      ADDR_CTRL: reg_rdata = {head.data[MAX_BITS-1] & !fifo_empty, ctrl_q};
      default:   reg_rdata = 8'h00;
    endcase
  end

  assign rx_ready = !fifo_empty;
  assign rx_irq   = ctrl_q[1] & gie & !fifo_empty;

  // R4: a character only waits in the shift stage while the buffer is full
  a_r4_pending_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_q |-> fifo_full);

  // R5: overrun only follows a full buffer with a waiting character
  a_r5_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(pend_valid_q && fifo_full));

  // R10: a character starts waiting only if it passed the address filter
  a_r10_pending_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_valid_q) |-> $past(frame_done && (!mpm_q || frame_word[MAX_BITS-1])));

  // R11: the interrupt never fires on an empty buffer
  a_r11_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_ready);
endmodule

// File: tb/uart_rx_buffered_test.sv
module uart_rx_buffered_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       rxd = 1'b1;
  logic       gie = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       rx_ready, rx_irq;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_buffered uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd), .gie(gie),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .rx_ready(rx_ready), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rest(input logic [8:0] d, input int nb, input int pm,
                           input logic pflip, input logic stopv, input int osr);
    logic p;
    p = 1'b0;
    for (int i = 0; i < nb; i++) begin
      hold(d[i], osr);
      p = p ^ d[i];
    end
    if (pm != 0) hold(p ^ (pm == 2) ^ pflip, osr);
    hold(stopv, osr);
    hold(1'b1, 2 * osr);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input int pm,
                      input logic pflip, input logic stopv, input int osr);
    @(negedge clk);
    hold(1'b0, osr);
    send_rest(d, nb, pm, pflip, stopv, osr);
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    chk(req, {24'h0, v}, {24'h0, e});
  endtask

  task automatic t_reset;
    expect_reg("R1 data", 2'd0, 8'h00);
    expect_reg("R1 status", 2'd1, 8'h00);
    expect_reg("R1 control", 2'd2, 8'h00);
    chk("R1 ready", {31'h0, rx_ready}, 0);
    chk("R1 irq", {31'h0, rx_irq}, 0);
  endtask

  task automatic t_basic;
    send(9'h0A5, 8, 0, 0, 1, 16);
    send(9'h03C, 8, 0, 0, 1, 16);
    chk("R3 ready pin", {31'h0, rx_ready}, 1);
    expect_reg("R3 status ready", 2'd1, 8'h01);
    expect_reg("R2 first char", 2'd0, 8'hA5);
    expect_reg("R3 second char", 2'd0, 8'h3C);
    expect_reg("R3 empty after reads", 2'd1, 8'h00);
  endtask

  task automatic t_sizes;
    wr(2'd2, 8'h01);
    send(9'h015, 5, 0, 0, 1, 16);
    expect_reg("R2 five bits", 2'd0, 8'h15);
    wr(2'd2, 8'h41);
    send(9'h1A5, 9, 0, 0, 1, 16);
    expect_reg("R2 ninth bit in control", 2'd2, 8'hC1);
    expect_reg("R2 nine bit data", 2'd0, 8'hA5);
    wr(2'd2, 8'h31);
  endtask

  task automatic t_frame_err;
    send(9'h05A, 8, 0, 0, 0, 16);
    send(9'h0C3, 8, 0, 0, 1, 16);
    expect_reg("R6 frame error on head", 2'd1, 8'h03);
    expect_reg("R6 bad-stop char", 2'd0, 8'h5A);
    expect_reg("R8 flags follow next entry", 2'd1, 8'h01);
    expect_reg("R8 next char", 2'd0, 8'hC3);
  endtask

  task automatic t_parity;
    wr(2'd2, 8'h39);
    send(9'h05A, 8, 1, 0, 1, 16);
    send(9'h037, 8, 1, 1, 1, 16);
    expect_reg("R7 even parity ok", 2'd1, 8'h01);
    wr(2'd2, 8'h31);
    expect_reg("R7 char a", 2'd0, 8'h5A);
    expect_reg("R7 stored flag survives disable", 2'd1, 8'h05);
    expect_reg("R7 char b", 2'd0, 8'h37);
    wr(2'd2, 8'h3D);
    send(9'h081, 8, 2, 0, 1, 16);
    expect_reg("R7 odd parity ok", 2'd1, 8'h01);
    expect_reg("R7 odd char", 2'd0, 8'h81);
    wr(2'd2, 8'h31);
  endtask

  task automatic t_overrun;
    send(9'h001, 8, 0, 0, 1, 16);
    send(9'h002, 8, 0, 0, 1, 16);
    send(9'h003, 8, 0, 0, 1, 16);
    send(9'h004, 8, 0, 0, 1, 16);
    expect_reg("R5 overrun flagged", 2'd1, 8'h09);
    expect_reg("R5 head kept", 2'd0, 8'h01);
    expect_reg("R5 flag cleared by read", 2'd1, 8'h01);
    expect_reg("R3 second kept", 2'd0, 8'h02);
    expect_reg("R4 waiting char entered", 2'd0, 8'h04);
    expect_reg("R5 buffer drained", 2'd1, 8'h00);
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    send(9'h011, 8, 0, 0, 1, 16);
    send(9'h022, 8, 0, 0, 1, 16);
    send(9'h033, 8, 0, 0, 1, 16);
    @(negedge clk);
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    reg_addr = 2'd0; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    repeat (3) @(negedge clk);
    send_rest(9'h044, 8, 0, 0, 1, 16);
    chk("R5 read at start cycle", {24'h0, v}, 32'h11);
    expect_reg("R5 no overrun on same-cycle read", 2'd1, 8'h01);
    expect_reg("R4 order b", 2'd0, 8'h22);
    expect_reg("R4 order c", 2'd0, 8'h33);
    expect_reg("R4 order d", 2'd0, 8'h44);
  endtask

  task automatic t_double;
    wr(2'd1, 8'h10);
    send(9'h06E, 8, 0, 0, 1, 8);
    expect_reg("R9 status fast", 2'd1, 8'h11);
    expect_reg("R9 fast char", 2'd0, 8'h6E);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_multi;
    wr(2'd1, 8'h20);
    send(9'h0C3, 9, 0, 0, 0, 16);
    expect_reg("R10 data frame dropped", 2'd1, 8'h20);
    send(9'h1C3, 9, 0, 0, 1, 16);
    expect_reg("R10 address frame kept", 2'd1, 8'h21);
    expect_reg("R10 ninth bit", 2'd2, 8'hB1);
    expect_reg("R10 address data", 2'd0, 8'hC3);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_irq;
    wr(2'd2, 8'h33);
    send(9'h042, 8, 0, 0, 1, 16);
    chk("R11 irq gated by gie", {31'h0, rx_irq}, 0);
    @(negedge clk); gie = 1'b1; #1;
    chk("R11 irq raised", {31'h0, rx_irq}, 1);
    expect_reg("R11 char", 2'd0, 8'h42);
    #1 chk("R11 irq falls when empty", {31'h0, rx_irq}, 0);
    gie = 1'b0;
    wr(2'd2, 8'h31);
  endtask

  task automatic t_status_write;
    send(9'h011, 8, 0, 0, 0, 16);
    wr(2'd1, 8'hFF);
    expect_reg("R12 only speed and filter written", 2'd1, 8'h33);
    wr(2'd1, 8'h00);
    expect_reg("R12 flags not clearable", 2'd1, 8'h03);
    expect_reg("R12 char", 2'd0, 8'h11);
  endtask

  task automatic t_false_start;
    @(negedge clk);
    hold(1'b0, 4);
    hold(1'b1, 48);
    expect_reg("R13 glitch stores nothing", 2'd1, 8'h00);
    send(9'h07E, 8, 0, 0, 1, 16);
    expect_reg("R13 recovers", 2'd0, 8'h7E);
  endtask

  task automatic t_disable;
    wr(2'd2, 8'h30);
    send(9'h099, 8, 0, 0, 1, 16);
    expect_reg("R14 disabled receives nothing", 2'd1, 8'h00);
    wr(2'd2, 8'h31);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    wr(2'd2, 8'h31);
    t_basic();
    t_sizes();
    t_frame_err();
    t_parity();
    t_overrun();
    t_same_cycle();
    t_double();
    t_multi();
    t_irq();
    t_status_write();
    t_false_start();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule